// File: doc/BRIEF.md
# Addressable Latch Host Sequencer

This block sits on the host side of an eight-channel addressable output latch. It drives the latch's address lines, data line, active-low select strobe and active-low clear line. A client hands it one command at a time over a valid/ready handshake, and the sequencer turns each command into a correctly timed waveform on the latch pins. The setup, strobe width, hold and clear width are all clock-cycle parameters, and their defaults are derived from a nanosecond clock period.

There are three kinds of command. A single write puts one channel index and one on/off value on the pins and strobes the select line once. A bulk write drives every channel to the same level. It does this by keeping the select strobe low and walking the address in reflected-binary order, so consecutive addresses differ in one bit and no channel outside the sequence is touched on the way. A bank clear pulses the clear line. The fourth opcode is accepted and does nothing.

Top module: `alseq_top`

## Requirements
- R1: Out of reset and whenever no command is in progress, `lat_sel_n` and `lat_clr_n` are high and `cmd_ready` is high.
- R2: Opcode 2'b00 (single write) drives `cmd_chan` as a binary index onto `lat_addr` and `cmd_val` onto `lat_data`. It then holds `lat_sel_n` low for exactly SEL_CYC consecutive cycles, with address and data unchanged.
- R3: Before `lat_sel_n` falls, address and data hold their final values for at least SETUP_CYC cycles.
- R4: After `lat_sel_n` rises, address and data stay unchanged and `cmd_ready` stays low for at least HOLD_CYC cycles.
- R5: Opcode 2'b01 (bulk write) drives `cmd_val` onto `lat_data` and keeps `lat_sel_n` low without a break. During that time `lat_addr` goes through 0,1,3,2,6,7,5,4, and each address is held for exactly SEL_CYC cycles.
- R6: While `lat_sel_n` stays low, `lat_addr` changes by at most one bit from one cycle to the next.
- R7: Opcode 2'b10 (bank clear) holds `lat_clr_n` low for exactly CLR_CYC consecutive cycles. `lat_sel_n` stays high for the whole command.
- R8: Opcode 2'b11 is accepted in one cycle and causes no activity on the latch lines. `cmd_ready` stays high.
- R9: `cmd_ready` is low from the cycle after a command is accepted until that command's final timing window ends. A `cmd_valid` raised during that time is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | The sequencer can accept a command |
| cmd_op | input | 2 | Opcode: 00 write, 01 bulk, 10 clear, 11 no-op |
| cmd_chan | input | 3 | Channel index for a single write |
| cmd_val | input | 1 | Level to write (1 = on) |
| lat_addr | output | 3 | Latch address lines |
| lat_data | output | 1 | Latch data line |
| lat_sel_n | output | 1 | Latch select strobe, active low |
| lat_clr_n | output | 1 | Latch clear, active low |

## Verification
The hardest case to reach from the ports is a command offered while the sequencer is still busy. If that command were taken, it would start a clear in the middle of a strobe or its hold window. The bench leaves `cmd_valid` high with a clear opcode for the whole of a single write and drops it on the same falling edge at which it sees `cmd_ready` return. It then checks that the clear line never moved. A second difficult point is the bulk walk. About a thousand cycles of continuous strobe must be split into eight dwell windows of exactly the right length in reflected-binary order. The bench records every cycle of the command and measures each run of a constant address.

// File: rtl/alseq_pkg.sv
package alseq_pkg;

   typedef enum logic [1:0] {
      OP_WRITE = 2'b00,
      OP_BULK  = 2'b01,
      OP_CLEAR = 2'b10,
      OP_NOP   = 2'b11
   } alseq_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_STROBE,
      ST_HOLD,
      ST_CLR
   } alseq_st_e;

   function automatic int ns_to_cyc(input int ns, input int period_ns);
      return (ns + period_ns - 1) / period_ns;
   endfunction

   function automatic int max4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/alseq_gray.sv
module alseq_gray #(
   parameter int AW = 3
) (
   input  logic [AW-1:0] step_i,
   output logic [AW-1:0] code_o
);
   // reflected-binary code of the step index
   assign code_o = step_i ^ (step_i >> 1);
endmodule

// File: rtl/alseq_timer.sv
module alseq_timer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [CW-1:0] load_val_i,
   output logic          done_o
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load_i)
         cnt_q <= load_val_i;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign done_o = (cnt_q == '0);
endmodule

// File: rtl/alseq_top.sv
module alseq_top
   import alseq_pkg::*;
#(
   parameter int NCH       = 8,
   parameter int CLK_NS    = 4,
   parameter int SETUP_NS  = 400,
   parameter int HOLD_NS   = 50,
   parameter int SEL_NS    = 500,
   parameter int CLR_NS    = 500,
   parameter int SETUP_CYC = ns_to_cyc(SETUP_NS, CLK_NS),
   parameter int HOLD_CYC  = ns_to_cyc(HOLD_NS, CLK_NS),
   parameter int SEL_CYC   = ns_to_cyc(SEL_NS, CLK_NS),
   parameter int CLR_CYC   = ns_to_cyc(CLR_NS, CLK_NS)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_valid,
   output logic       cmd_ready,
   input  logic [1:0] cmd_op,
   input  logic [2:0] cmd_chan,
   input  logic       cmd_val,
   output logic [2:0] lat_addr,
   output logic       lat_data,
   output logic       lat_sel_n,
   output logic       lat_clr_n
);
   localparam int AW     = $clog2(NCH);
   localparam int MAXCYC = max4(SETUP_CYC, HOLD_CYC, SEL_CYC, CLR_CYC);
   localparam int CW     = $clog2(MAXCYC + 1);
   localparam logic [AW-1:0] LAST_STEP = AW'(NCH - 1);

   // elaboration-time parameter checks
   if (NCH < 2 || (NCH & (NCH - 1)) != 0) begin : g_bad_nch
      $error("NCH must be a power of two of at least 2");
   end
   if (AW != 3) begin : g_bad_aw
      $error("port widths are fixed for eight channels");
   end
   if (SETUP_CYC < 1 || HOLD_CYC < 1 || SEL_CYC < 1 || CLR_CYC < 1) begin : g_bad_cyc
      $error("every timing window needs at least one cycle");
   end

   alseq_st_e     state_q;
   logic          bulk_q;
   logic [AW-1:0] step_q;
   logic [AW-1:0] addr_q;
   logic          data_q;
   logic          sel_n_q;
   logic          clr_n_q;

   logic          accept;
   logic          tmr_ld;
   logic [CW-1:0] tmr_val;
   logic          tmr_done;
   logic [AW-1:0] step_nx;
   logic [AW-1:0] code_nx;
   logic          walk_more;

   assign cmd_ready = (state_q == ST_IDLE);
   assign accept    = cmd_valid && cmd_ready;
   assign step_nx   = step_q + 1'b1;
   assign walk_more = bulk_q && (step_q != LAST_STEP);

   alseq_gray #(.AW(AW)) gray_i (
      .step_i (step_nx),
      .code_o (code_nx)
   );

   alseq_timer #(.CW(CW)) tmr_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (tmr_ld),
      .load_val_i (tmr_val),
      .done_o     (tmr_done)
   );

   always_comb begin
      tmr_ld  = 1'b0;
      tmr_val = '0;
      unique case (state_q)
         ST_IDLE: begin
            if (accept) begin
               if (cmd_op == OP_WRITE || cmd_op == OP_BULK) begin
                  tmr_ld  = 1'b1;
                  tmr_val = CW'(SETUP_CYC - 1);
               end else if (cmd_op == OP_CLEAR) begin
                  tmr_ld  = 1'b1;
                  tmr_val = CW'(CLR_CYC - 1);
               end
            end
         end
         ST_SETUP: begin
            if (tmr_done) begin
               tmr_ld  = 1'b1;
               tmr_val = CW'(SEL_CYC - 1);
            end
         end
         ST_STROBE: begin
            if (tmr_done) begin
               tmr_ld  = 1'b1;
               tmr_val = walk_more ? CW'(SEL_CYC - 1) : CW'(HOLD_CYC - 1);
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         bulk_q  <= 1'b0;
         step_q  <= '0;
         addr_q  <= '0;
         data_q  <= 1'b0;
         sel_n_q <= 1'b1;
         clr_n_q <= 1'b1;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  unique case (cmd_op)
                     OP_WRITE: begin
                        bulk_q  <= 1'b0;
                        addr_q  <= cmd_chan;
                        data_q  <= cmd_val;
                        state_q <= ST_SETUP;
                     end
                     OP_BULK: begin
                        bulk_q  <= 1'b1;
                        step_q  <= '0;
                        addr_q  <= '0;
                        data_q  <= cmd_val;
                        state_q <= ST_SETUP;
                     end
                     OP_CLEAR: begin
                        clr_n_q <= 1'b0;
                        state_q <= ST_CLR;
                     end
                     default: ;
                  endcase
               end
            end
            ST_SETUP: begin
               if (tmr_done) begin
                  sel_n_q <= 1'b0;
                  state_q <= ST_STROBE;
               end
            end
            ST_STROBE: begin
               if (tmr_done) begin
                  if (walk_more) begin
                     step_q <= step_nx;
                     addr_q <= code_nx;
                  end else begin
                     sel_n_q <= 1'b1;
                     state_q <= ST_HOLD;
                  end
               end
            end
            ST_HOLD: begin
               if (tmr_done) state_q <= ST_IDLE;
            end
            ST_CLR: begin
               if (tmr_done) begin
                  clr_n_q <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign lat_addr  = addr_q;
   assign lat_data  = data_q;
   assign lat_sel_n = sel_n_q;
   assign lat_clr_n = clr_n_q;

   // R1: both latch control lines idle whenever the handshake is open
   a_r1_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> (lat_sel_n && lat_clr_n));

   // R3: address and data are already settled when the strobe falls
   a_r3_setup_stable: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lat_sel_n) |-> ($stable(lat_addr) && $stable(lat_data)));

   // R4: address and data do not move on the strobe's rising edge
   a_r4_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lat_sel_n) |-> ($stable(lat_addr) && $stable(lat_data) && !cmd_ready));

   // R5: data level is constant while the strobe is low
   a_r5_data_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (!lat_sel_n && !$past(lat_sel_n)) |-> $stable(lat_data));

   // R6: one address bit at most changes during a continuous strobe
   a_r6_one_bit_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!lat_sel_n && !$past(lat_sel_n)) |-> ($countones(lat_addr ^ $past(lat_addr)) <= 1));

   // R7: clear and strobe never overlap
   a_r7_clr_excl_sel: assert property (@(posedge clk) disable iff (!rst_n)
      !lat_clr_n |-> lat_sel_n);

   // R9: a command offered while busy leaves the control lines alone
   a_r9_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_ready && lat_clr_n && lat_sel_n && !$rose(lat_sel_n)) |=> lat_clr_n);

endmodule

// File: tb/alseq_top_tb_top.sv
module alseq_top_tb_top;
   localparam int CLK_NS    = 4;
   localparam int SETUP_CYC = (400 + CLK_NS - 1) / CLK_NS;
   localparam int HOLD_CYC  = (50 + CLK_NS - 1) / CLK_NS;
   localparam int SEL_CYC   = (500 + CLK_NS - 1) / CLK_NS;
   localparam int CLR_CYC   = (500 + CLK_NS - 1) / CLK_NS;
   localparam int MAXS      = 2048;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic       cmd_ready;
   logic [1:0] cmd_op = 2'b00;
   logic [2:0] cmd_chan = 3'd0;
   logic       cmd_val = 1'b0;
   logic [2:0] lat_addr;
   logic       lat_data;
   logic       lat_sel_n;
   logic       lat_clr_n;

   int n_chk  = 0;
   int n_fail = 0;
   int nsmp;
   logic       s_sel  [MAXS];
   logic       s_clr  [MAXS];
   logic [2:0] s_addr [MAXS];
   logic       s_data [MAXS];

   always #(CLK_NS / 2) clk = ~clk;

   alseq_top dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_ready (cmd_ready),
      .cmd_op    (cmd_op),
      .cmd_chan  (cmd_chan),
      .cmd_val   (cmd_val),
      .lat_addr  (lat_addr),
      .lat_data  (lat_data),
      .lat_sel_n (lat_sel_n),
      .lat_clr_n (lat_clr_n)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // offer one command, then record every cycle until ready returns
   task automatic run_cmd(input logic [1:0] op, input logic [2:0] ch, input logic v,
                          input bit poke);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_op    = op;
      cmd_chan  = ch;
      cmd_val   = v;
      @(negedge clk);
      if (poke) cmd_op = 2'b10;
      else cmd_valid = 1'b0;
      nsmp = 0;
      while (!cmd_ready && nsmp < MAXS) begin
         s_sel[nsmp]  = lat_sel_n;
         s_clr[nsmp]  = lat_clr_n;
         s_addr[nsmp] = lat_addr;
         s_data[nsmp] = lat_data;
         nsmp++;
         @(negedge clk);
      end
      cmd_valid = 1'b0;
   endtask

   task automatic check_idle(input string tag);
      chk(lat_sel_n === 1'b1, {"R1 sel idle ", tag}, int'(lat_sel_n), 1);
      chk(lat_clr_n === 1'b1, {"R1 clr idle ", tag}, int'(lat_clr_n), 1);
      chk(cmd_ready === 1'b1, {"R1 ready idle ", tag}, int'(cmd_ready), 1);
   endtask

   task automatic low_span(output int first, output int last, output int cnt);
      first = -1; last = -1; cnt = 0;
      for (int i = 0; i < nsmp; i++) begin
         if (s_sel[i] == 1'b0) begin
            if (first < 0) first = i;
            last = i;
            cnt++;
         end
      end
   endtask

   task automatic t_write(input logic [2:0] ch, input logic v, input bit poke);
      int first, last, cnt, bad;
      run_cmd(2'b00, ch, v, poke);
      low_span(first, last, cnt);
      chk(nsmp > 0, "R9 ready low after accept", nsmp, 1);
      chk(first >= SETUP_CYC, "R3 setup cycles", first, SETUP_CYC);
      bad = 0;
      for (int i = 0; i <= first && i < nsmp; i++)
         if (s_addr[i] != ch || s_data[i] != v) bad++;
      chk(bad == 0, "R3 addr/data settled before strobe", bad, 0);
      chk(cnt == SEL_CYC && cnt == last - first + 1, "R2 strobe width", cnt, SEL_CYC);
      bad = 0;
      for (int i = first; i <= last; i++)
         if (s_addr[i] != ch || s_data[i] != v) bad++;
      chk(bad == 0, "R2 addr/data during strobe", bad, 0);
      chk(nsmp - 1 - last >= HOLD_CYC, "R4 hold cycles", nsmp - 1 - last, HOLD_CYC);
      bad = 0;
      for (int i = last + 1; i < nsmp; i++)
         if (s_addr[i] != ch || s_data[i] != v) bad++;
      chk(bad == 0, "R4 addr/data in hold", bad, 0);
      bad = 0;
      for (int i = 0; i < nsmp; i++) if (s_clr[i] == 1'b0) bad++;
      chk(bad == 0, "R9 busy command ignored", bad, 0);
      check_idle("after write");
   endtask

   task automatic t_bulk(input logic v);
      int first, last, cnt, seg, dwell, bad, onebit;
      logic [2:0] expseq [8] = '{3'd0, 3'd1, 3'd3, 3'd2, 3'd6, 3'd7, 3'd5, 3'd4};
      run_cmd(2'b01, 3'd0, v, 1'b0);
      low_span(first, last, cnt);
      chk(first >= SETUP_CYC, "R3 bulk setup", first, SETUP_CYC);
      chk(cnt == 8 * SEL_CYC && cnt == last - first + 1, "R5 continuous strobe", cnt, 8 * SEL_CYC);
      seg = 0; dwell = 0; bad = 0; onebit = 0;
      for (int i = first; i <= last && first >= 0; i++) begin
         if (i > first && s_addr[i] != s_addr[i-1]) begin
            if (dwell != SEL_CYC) bad++;
            if ($countones(s_addr[i] ^ s_addr[i-1]) != 1) onebit++;
            seg++;
            dwell = 0;
         end
         if (seg < 8 && s_addr[i] != expseq[seg]) bad++;
         if (s_data[i] != v) bad++;
         dwell++;
      end
      chk(seg == 7, "R5 address segments", seg + 1, 8);
      chk(dwell == SEL_CYC, "R5 last dwell", dwell, SEL_CYC);
      chk(bad == 0, "R5 order/dwell/data", bad, 0);
      chk(onebit == 0, "R6 single-bit steps", onebit, 0);
      chk(nsmp - 1 - last >= HOLD_CYC, "R4 bulk hold", nsmp - 1 - last, HOLD_CYC);
      check_idle("after bulk");
   endtask

   task automatic t_clear();
      int first, cnt, last, sel_low;
      run_cmd(2'b10, 3'd0, 1'b0, 1'b0);
      first = -1; last = -1; cnt = 0; sel_low = 0;
      for (int i = 0; i < nsmp; i++) begin
         if (s_clr[i] == 1'b0) begin
            if (first < 0) first = i;
            last = i;
            cnt++;
         end
         if (s_sel[i] == 1'b0) sel_low++;
      end
      chk(cnt == CLR_CYC && cnt == last - first + 1, "R7 clear width", cnt, CLR_CYC);
      chk(sel_low == 0, "R7 strobe stays high", sel_low, 0);
      check_idle("after clear");
   endtask

   task automatic t_nop();
      int act;
      run_cmd(2'b11, 3'd2, 1'b1, 1'b0);
      chk(nsmp == 0, "R8 nop keeps ready", nsmp, 0);
      act = 0;
      for (int i = 0; i < 20; i++) begin
         if (!lat_sel_n || !lat_clr_n || !cmd_ready) act++;
         @(negedge clk);
      end
      chk(act == 0, "R8 nop line activity", act, 0);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_idle("reset");
      t_write(3'd5, 1'b1, 1'b0);
      t_write(3'd0, 1'b0, 1'b0);
      t_write(3'd7, 1'b1, 1'b0);
      t_bulk(1'b1);
      t_bulk(1'b0);
      t_clear();
      t_nop();
      t_write(3'd3, 1'b1, 1'b1);
      t_write(3'd6, 1'b0, 1'b0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule